// File: doc/BRIEF.md
# Single-Frame Host Packet Buffer

This block sits between a host processor's register bus and the frame streams of a small management Ethernet port. Each direction holds one frame at a time. To send, the host pushes 32-bit words into a transmit data window. It then writes a transmit control word that carries the byte count and a start bit. The block streams the stored words to the MAC side and reports busy and error status back in the same control word. On receive, the MAC side writes an incoming frame into a one-frame buffer. The host reads the frame status and length from a receive control word and then pulls the frame out through a receive data window. Writing zero to the receive control word releases the buffer.

One interrupt line combines two causes. The first is a level cause while a received frame waits. The second is a transmit-completion cause that is latched only if its enable bit is set when the completion happens. The word count of a frame is always the byte count divided by four, rounded up. The last word carries the one to three trailing bytes of a length that is not a multiple of four.

Top module: `fmb_host_port`

## Requirements
- R1: After reset, the transmit control (address 1), receive control (address 3) and interrupt enable (address 4) registers read zero, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: Words written to address 0 are streamed on `tx_data` in write order. A frame of L bytes produces exactly ceil(L/4) beats, `tx_last` is set on the final beat only, and `tx_len` shows L.
- R3: A write to address 1 with bit 31 set and byte count L in bits [LEN_W-1:0] launches a frame. Bit 31 then reads 1 until the final beat is accepted, and 0 afterwards. Bit 30 reads the level of `tx_fail` at the final beat. `tx_valid` and `tx_data` hold while `tx_ready` is low.
- R4: While a frame is in progress, writes to address 0 and address 1 are ignored. A launch with L = 0 or L > MAX_BYTES is also ignored.
- R5: After completion, address 1 keeps the byte count and error flag. Writing zero to address 1 clears them.
- R6: After the final receive beat (`rx_last`), address 3 reads bit 31 = ready, bit 30 = `rx_err`, bit 29 = `rx_crc_err`, and bits [LEN_W-1:0] = `rx_len`. `rx_ready` stays low and further input is not accepted until acknowledge.
- R7: Reads of address 2 return the stored receive words in arrival order. Each read advances to the next word.
- R8: Writing zero to address 3 clears its fields, raises `rx_ready`, and restarts the next frame's readout at its first word. A nonzero write to address 3 has no effect.
- R9: Interrupt enable bit 0 gates the receive cause. `irq` is high while a frame is ready and bit 0 is set.
- R10: Enable bit 1 latches a pending transmit interrupt at completion. A completion that happens while bit 1 is clear never raises `irq`, even if bit 1 is set later. The pending flag is cleared by writing zero to address 1 or by clearing bit 1.
- R11: A read of address 2 with no frame ready returns zero and does not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined interrupt |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | MAC accepts transmit word |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of frame |
| tx_len | output | LEN_W | Byte count of the frame being sent |
| tx_fail | input | 1 | MAC transmit failure, sampled on final beat |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Buffer free to accept receive words |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Final receive word |
| rx_len | input | LEN_W | Received byte count, with final word |
| rx_err | input | 1 | Receive error, with final word |
| rx_crc_err | input | 1 | CRC error, with final word |

## Verification
Register reads return data one cycle after the strobe edge. A launch shows busy from the next edge. Completion status and the transmit interrupt appear on the edge that accepts the final beat. Receive ready and its interrupt appear on the edge that takes `rx_last`, and an acknowledge takes effect on the following edge. The bench drives all inputs on falling edges and samples one falling edge after the edge that is due to change a result. The first busy read after a launch is therefore taken before the earliest possible final beat. The bench sweeps every byte length from 1 to the configured maximum in both directions, and derives word counts and patterns arithmetically.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
    localparam logic [2:0] ADDR_TX_WORD = 3'd0;
    localparam logic [2:0] ADDR_TX_CTL  = 3'd1;
    localparam logic [2:0] ADDR_RX_WORD = 3'd2;
    localparam logic [2:0] ADDR_RX_CTL  = 3'd3;
    localparam logic [2:0] ADDR_IRQ_EN  = 3'd4;

    localparam int BIT_TX_GO  = 31;
    localparam int BIT_TX_ERR = 30;
    localparam int BIT_RX_RDY = 31;
    localparam int BIT_RX_ERR = 30;
    localparam int BIT_RX_CRC = 29;
endpackage

// File: rtl/fmb_tx_buf.sv
module fmb_tx_buf #(
    parameter int MAX_BYTES = 256,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [31:0]      push_data,
    input  logic             ctl_wr,
    input  logic [31:0]      ctl_data,
    output logic             busy,
    output logic             err,
    output logic [LEN_W-1:0] len,
    output logic             done,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    input  logic             tx_fail
);
    import fmb_pkg::*;

    localparam int DEPTH = (MAX_BYTES + 3) / 4;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             busy;
        logic             err;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] nwords;
        logic [CNT_W-1:0] rd_ptr;
        logic [CNT_W-1:0] wr_ptr;
    } tx_state_t;

    tx_state_t   q, d;
    logic [31:0] mem_q [DEPTH];

    logic             launch, clr, push_ok, beat, at_last;
    logic [LEN_W:0]   len_ext, words_ext;

    always_comb begin
        len_ext   = {1'b0, ctl_data[LEN_W-1:0]};
        words_ext = (len_ext + (LEN_W+1)'(3)) >> 2;
        launch    = ctl_wr && ctl_data[BIT_TX_GO] && !q.busy && (len_ext != '0)
                    && (len_ext <= (LEN_W+1)'(MAX_BYTES));
        clr       = ctl_wr && (ctl_data == 32'd0) && !q.busy;
        push_ok   = push && !q.busy && (q.wr_ptr < CNT_W'(DEPTH));
        at_last   = (q.rd_ptr == q.nwords - CNT_W'(1));
        beat      = q.busy && tx_ready;

        d = q;
        if (push_ok) d.wr_ptr = q.wr_ptr + CNT_W'(1);
        if (clr) begin
            d.err = 1'b0;
            d.len = '0;
        end
        if (launch) begin
            d.busy   = 1'b1;
            d.err    = 1'b0;
            d.len    = ctl_data[LEN_W-1:0];
            d.nwords = words_ext[CNT_W-1:0];
            d.rd_ptr = '0;
            d.wr_ptr = '0;
        end
        if (beat) begin
            if (at_last) begin
                d.busy = 1'b0;
                d.err  = tx_fail;
            end else begin
                d.rd_ptr = q.rd_ptr + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[q.wr_ptr[IDX_W-1:0]] <= push_data;
    end

    assign busy     = q.busy;
    assign err      = q.err;
    assign len      = q.len;
    assign done     = beat && at_last;
    assign tx_valid = q.busy;
    assign tx_data  = mem_q[q.rd_ptr[IDX_W-1:0]];
    assign tx_last  = q.busy && at_last;

    // R3: a stalled beat keeps its word
    a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4: pushes never land while a frame is being sent
    a_r4_no_push_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.wr_ptr == '0));

    // R2: read position stays inside the launched word count
    a_r2_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.rd_ptr < q.nwords));
endmodule

// File: rtl/fmb_rx_buf.sv
module fmb_rx_buf #(
    parameter int MAX_BYTES = 256,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [31:0]      rx_data,
    input  logic             rx_last,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_err,
    input  logic             rx_crc_err,
    input  logic             pop,
    input  logic             ack,
    output logic             rdy,
    output logic             err,
    output logic             crc,
    output logic [LEN_W-1:0] len,
    output logic [31:0]      pop_data
);
    localparam int DEPTH = (MAX_BYTES + 3) / 4;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             rdy;
        logic             err;
        logic             crc;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] wr_ptr;
        logic [CNT_W-1:0] rd_ptr;
    } rx_state_t;

    rx_state_t   q, d;
    logic [31:0] mem_q [DEPTH];

    logic accept, store, pop_ok, rd_in_range;

    always_comb begin
        accept      = rx_valid && !q.rdy;
        store       = accept && (q.wr_ptr < CNT_W'(DEPTH));
        rd_in_range = q.rd_ptr < CNT_W'(DEPTH);
        pop_ok      = pop && q.rdy && rd_in_range;

        d = q;
        if (pop_ok) d.rd_ptr = q.rd_ptr + CNT_W'(1);
        if (ack) begin
            d.rdy    = 1'b0;
            d.err    = 1'b0;
            d.crc    = 1'b0;
            d.len    = '0;
            d.rd_ptr = '0;
        end
        if (accept) begin
            if (rx_last) begin
                d.rdy    = 1'b1;
                d.err    = rx_err;
                d.crc    = rx_crc_err;
                d.len    = rx_len;
                d.wr_ptr = '0;
                d.rd_ptr = '0;
            end else if (store) begin
                d.wr_ptr = q.wr_ptr + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (store) mem_q[q.wr_ptr[IDX_W-1:0]] <= rx_data;
    end

    assign rx_ready = !q.rdy;
    assign rdy      = q.rdy;
    assign err      = q.err;
    assign crc      = q.crc;
    assign len      = q.len;
    assign pop_data = (q.rdy && rd_in_range) ? mem_q[q.rd_ptr[IDX_W-1:0]] : 32'd0;

    // R8: a waiting frame stays put until acknowledged
    a_r8_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rdy && !ack) |=> (q.rdy && $stable(q.len) && $stable(q.wr_ptr)));

    // R7: readout position never runs past the buffer
    a_r7_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_ptr <= CNT_W'(DEPTH));
endmodule

// File: rtl/fmb_irq.sv
module fmb_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_wr,
    input  logic [1:0] en_data,
    input  logic       tx_clr,
    input  logic       tx_done,
    input  logic       rx_rdy,
    output logic [1:0] en,
    output logic       irq
);
    typedef struct packed {
        logic [1:0] en;
        logic       pend;
    } irq_state_t;

    irq_state_t q, d;

    always_comb begin
        d = q;
        if (en_wr) begin
            d.en = en_data;
            if (!en_data[1]) d.pend = 1'b0;
        end
        if (tx_clr) d.pend = 1'b0;
        if (tx_done && q.en[1]) d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en  = q.en;
    assign irq = (rx_rdy && q.en[0]) || q.pend;

    // R10: a masked completion leaves nothing pending
    a_r10_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !q.en[1] && !q.pend) |=> !q.pend);

    // R10: an enabled completion raises the line
    a_r10_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && q.en[1]) |=> irq);
endmodule

// File: rtl/fmb_host_port.sv
module fmb_host_port #(
    parameter int MAX_BYTES = 256,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [2:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             irq,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    output logic [LEN_W-1:0] tx_len,
    input  logic             tx_fail,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [31:0]      rx_data,
    input  logic             rx_last,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_err,
    input  logic             rx_crc_err
);
    import fmb_pkg::*;

    typedef struct packed {
        logic [31:0] rdata;
    } port_state_t;

    port_state_t q, d;

    logic wr_zero, tx_push, tx_ctl_wr, tx_clr, rx_pop, rx_ack, en_wr;
    logic tx_busy, tx_err, tx_done;
    logic [LEN_W-1:0] tx_len_q, rx_len_q;
    logic rx_rdy, rx_err_q, rx_crc_q;
    logic [31:0] rx_word;
    logic [1:0] irq_en;

    assign wr_zero   = (host_wdata == 32'd0);
    assign tx_push   = host_wr && (host_addr == ADDR_TX_WORD);
    assign tx_ctl_wr = host_wr && (host_addr == ADDR_TX_CTL);
    assign tx_clr    = tx_ctl_wr && wr_zero;
    assign rx_pop    = host_rd && (host_addr == ADDR_RX_WORD);
    assign rx_ack    = host_wr && (host_addr == ADDR_RX_CTL) && wr_zero;
    assign en_wr     = host_wr && (host_addr == ADDR_IRQ_EN);

    fmb_tx_buf #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (host_wdata),
        .ctl_wr    (tx_ctl_wr),
        .ctl_data  (host_wdata),
        .busy      (tx_busy),
        .err       (tx_err),
        .len       (tx_len_q),
        .done      (tx_done),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_fail   (tx_fail)
    );

    fmb_rx_buf #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_len     (rx_len),
        .rx_err     (rx_err),
        .rx_crc_err (rx_crc_err),
        .pop        (rx_pop),
        .ack        (rx_ack),
        .rdy        (rx_rdy),
        .err        (rx_err_q),
        .crc        (rx_crc_q),
        .len        (rx_len_q),
        .pop_data   (rx_word)
    );

    fmb_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (en_wr),
        .en_data (host_wdata[1:0]),
        .tx_clr  (tx_clr),
        .tx_done (tx_done),
        .rx_rdy  (rx_rdy),
        .en      (irq_en),
        .irq     (irq)
    );

    always_comb begin
        logic [31:0] word;
        word = 32'd0;
        unique case (host_addr)
            ADDR_TX_CTL: begin
                word[BIT_TX_GO]   = tx_busy;
                word[BIT_TX_ERR]  = tx_err;
                word[LEN_W-1:0]   = tx_len_q;
            end
            ADDR_RX_WORD: word = rx_word;
            ADDR_RX_CTL: begin
                word[BIT_RX_RDY]  = rx_rdy;
                word[BIT_RX_ERR]  = rx_err_q;
                word[BIT_RX_CRC]  = rx_crc_q;
                word[LEN_W-1:0]   = rx_len_q;
            end
            ADDR_IRQ_EN: word[1:0] = irq_en;
            default: word = 32'd0;
        endcase
        d = q;
        if (host_rd) d.rdata = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = q.rdata;
    assign tx_len     = tx_len_q;

    // R6: no receive word is taken while a frame waits
    a_r6_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy && !rx_ack) |=> !rx_ready);

    // R3: launch with busy clear makes busy visible next cycle
    a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctl_wr && host_wdata[BIT_TX_GO] && !tx_busy && (host_wdata[LEN_W-1:0] != '0)
         && ({1'b0, host_wdata[LEN_W-1:0]} <= (LEN_W+1)'(MAX_BYTES))) |=> tx_valid);
endmodule

// File: tb/tb_fmb_host_port.sv
module tb_fmb_host_port;
    localparam int MAXB  = 32;
    localparam int LW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          irq;
    logic          tx_valid, tx_last;
    logic          tx_ready = 1'b1;
    logic [31:0]   tx_data;
    logic [LW-1:0] tx_len;
    logic          tx_fail = 1'b0;
    logic          rx_valid = 1'b0, rx_ready, rx_last = 1'b0;
    logic [31:0]   rx_data = '0;
    logic [LW-1:0] rx_len = '0;
    logic          rx_err = 1'b0, rx_crc_err = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;
    bit hold_low = 0;
    int cyc = 0;
    logic [31:0] cap [16];
    logic        cap_last [16];
    int cap_n = 0;

    fmb_host_port #(.MAX_BYTES(MAXB), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_len(tx_len), .tx_fail(tx_fail),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_len(rx_len), .rx_err(rx_err), .rx_crc_err(rx_crc_err)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        tx_ready <= hold_low ? 1'b0 : ((cyc % 3) != 1);
    end

    always @(posedge clk) begin
        if (tx_valid && tx_ready && cap_n < 16) begin
            cap[cap_n] = tx_data;
            cap_last[cap_n] = tx_last;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    function automatic logic [31:0] tpat(input int len, input int i);
        return {len[7:0], i[7:0], 8'h5A, i[7:0] ^ 8'hC3};
    endfunction

    function automatic logic [31:0] rpat(input int len, input int i);
        return {len[7:0] ^ 8'hE0, i[7:0], len[7:0], i[7:0] + 8'h3C};
    endfunction

    task automatic wait_tx_idle(output logic [31:0] v);
        for (int k = 0; k < 200; k++) begin
            bus_read(3'd1, v);
            if (!v[31]) break;
        end
    endtask

    task automatic run_tx(input int len, input bit fail);
        logic [31:0] v;
        int nw;
        nw = (len + 3) / 4;
        for (int i = 0; i < nw; i++) bus_write(3'd0, tpat(len, i));
        cap_n = 0;
        tx_fail = fail;
        bus_write(3'd1, 32'h8000_0000 | 32'(len));
        bus_read(3'd1, v);
        chk(v[31] == 1'b1, "R3 busy after launch", v, 32'h8000_0000 | 32'(len));
        wait_tx_idle(v);
        chk(v[31] == 1'b0, "R3 busy clears", v, 32'(len));
        chk(v[30] == fail, "R3 error flag", {31'd0, v[30]}, {31'd0, fail});
        chk(v[LW-1:0] == LW'(len), "R5 length kept", v, 32'(len));
        chk(cap_n == nw, "R2 beat count", 32'(cap_n), 32'(nw));
        for (int i = 0; i < nw && i < 16; i++) begin
            chk(cap[i] == tpat(len, i), "R2 word order", cap[i], tpat(len, i));
            chk(cap_last[i] == (i == nw - 1), "R2 last flag", {31'd0, cap_last[i]}, {31'd0, i == nw - 1});
        end
        chk(tx_len == LW'(len), "R2 tx_len", 32'(tx_len), 32'(len));
        chk(irq == 1'b1, "R10 done raises irq", {31'd0, irq}, 32'd1);
        bus_write(3'd1, 32'd0);
        bus_read(3'd1, v);
        chk(v == 32'd0, "R5 zero write clears", v, 32'd0);
        chk(irq == 1'b0, "R10 cleared by zero write", {31'd0, irq}, 32'd0);
        tx_fail = 1'b0;
    endtask

    task automatic run_rx(input int len, input bit e, input bit c, input bit all);
        logic [31:0] v;
        int nw, nr;
        nw = (len + 3) / 4;
        chk(rx_ready == 1'b1, "R8 buffer free", {31'd0, rx_ready}, 32'd1);
        for (int i = 0; i < nw; i++) begin
            rx_valid = 1'b1; rx_data = rpat(len, i); rx_last = (i == nw - 1);
            rx_len = LW'(len); rx_err = e; rx_crc_err = c;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_crc_err = 1'b0;
        chk(rx_ready == 1'b0, "R6 held off", {31'd0, rx_ready}, 32'd0);
        chk(irq == 1'b1, "R9 rx irq", {31'd0, irq}, 32'd1);
        // further input while full must not be taken
        rx_valid = 1'b1; rx_data = 32'hDEAD_BEEF; rx_last = 1'b1; rx_len = LW'(7);
        @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        bus_read(3'd3, v);
        chk(v[31] == 1'b1 && v[30] == e && v[29] == c && v[LW-1:0] == LW'(len),
            "R6 status fields", v, {1'b1, e, c, 17'd0, LW'(len)});
        nr = all ? nw : 1;
        for (int i = 0; i < nr; i++) begin
            bus_read(3'd2, v);
            chk(v == rpat(len, i), "R7 read order", v, rpat(len, i));
        end
        bus_write(3'd3, 32'h0000_0001);
        bus_read(3'd3, v);
        chk(v[31] == 1'b1, "R8 nonzero write ignored", v, 32'h8000_0000);
        bus_write(3'd3, 32'd0);
        chk(rx_ready == 1'b1, "R8 ack frees", {31'd0, rx_ready}, 32'd1);
        chk(irq == 1'b0, "R9 irq drops on ack", {31'd0, irq}, 32'd0);
        bus_read(3'd3, v);
        chk(v == 32'd0, "R8 fields cleared", v, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq == 1'b0, "R1 irq low", {31'd0, irq}, 32'd0);
        chk(tx_valid == 1'b0, "R1 tx_valid low", {31'd0, tx_valid}, 32'd0);
        chk(rx_ready == 1'b1, "R1 rx_ready high", {31'd0, rx_ready}, 32'd1);
        bus_read(3'd1, v); chk(v == 0, "R1 tx ctl zero", v, 0);
        bus_read(3'd3, v); chk(v == 0, "R1 rx ctl zero", v, 0);
        bus_read(3'd4, v); chk(v == 0, "R1 irq enable zero", v, 0);

        // R11 empty read
        bus_read(3'd2, v); chk(v == 0, "R11 empty read zero", v, 0);

        bus_write(3'd4, 32'd3);
        bus_read(3'd4, v); chk(v == 32'd3, "R9 enable readback", v, 32'd3);

        for (int len = 1; len <= MAXB; len++) run_tx(len, (len % 5) == 0);

        // R4 writes ignored while busy
        hold_low = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_write(3'd0, 32'h1111_0001);
        bus_write(3'd0, 32'h1111_0002);
        cap_n = 0;
        bus_write(3'd1, 32'h8000_0008);
        bus_write(3'd0, 32'h2222_2222);
        bus_write(3'd1, 32'h8000_0004);
        bus_write(3'd1, 32'd0);
        bus_read(3'd1, v);
        chk(v == 32'h8000_0008, "R4 control ignored while busy", v, 32'h8000_0008);
        hold_low = 1'b0;
        wait_tx_idle(v);
        chk(cap_n == 2, "R4 beat count unchanged", 32'(cap_n), 32'd2);
        chk(cap[0] == 32'h1111_0001 && cap[1] == 32'h1111_0002, "R4 push ignored while busy",
            cap[1], 32'h1111_0002);
        chk(tx_len == LW'(8), "R4 length unchanged", 32'(tx_len), 32'd8);
        bus_write(3'd1, 32'd0);

        bus_write(3'd1, 32'h8000_0000);
        bus_read(3'd1, v);
        chk(v[31] == 1'b0 && tx_valid == 1'b0, "R4 zero length ignored", v, 32'd0);
        bus_write(3'd1, 32'h8000_0000 | 32'(MAXB + 1));
        bus_read(3'd1, v);
        chk(v[31] == 1'b0 && tx_valid == 1'b0, "R4 oversize ignored", v, 32'd0);

        // R10 masked completion stays silent
        bus_write(3'd4, 32'd1);
        bus_write(3'd0, 32'hABCD_0000);
        bus_write(3'd1, 32'h8000_0004);
        wait_tx_idle(v);
        chk(irq == 1'b0, "R10 masked completion silent", {31'd0, irq}, 32'd0);
        bus_write(3'd4, 32'd3);
        chk(irq == 1'b0, "R10 later enable no raise", {31'd0, irq}, 32'd0);
        bus_write(3'd1, 32'd0);
        // R10 clearing the enable drops a pending completion
        bus_write(3'd0, 32'hABCD_0001);
        bus_write(3'd1, 32'h8000_0003);
        wait_tx_idle(v);
        chk(irq == 1'b1, "R10 enabled completion", {31'd0, irq}, 32'd1);
        bus_write(3'd4, 32'd1);
        chk(irq == 1'b0, "R10 enable clear drops", {31'd0, irq}, 32'd0);
        bus_write(3'd1, 32'd0);

        // receive sweep
        for (int len = 1; len <= MAXB; len++)
            run_rx(len, (len % 4) == 1, (len % 5) == 2, (len % 3) != 0);

        // R9 masked receive cause
        bus_write(3'd4, 32'd0);
        rx_valid = 1'b1; rx_data = 32'h5555_AAAA; rx_last = 1'b1; rx_len = LW'(4);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        chk(irq == 1'b0, "R9 rx cause masked", {31'd0, irq}, 32'd0);
        bus_write(3'd4, 32'd1);
        chk(irq == 1'b1, "R9 rx cause enabled", {31'd0, irq}, 32'd1);
        bus_write(3'd3, 32'd0);
        bus_read(3'd2, v); chk(v == 0, "R11 read after ack zero", v, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule